// File: doc/BRIEF.md
# Byte-Parallel Sample Transmit Slice

This block turns 32-bit words from a host into a stream of 8-bit samples on a parallel output bus. An external sample clock sets the pace, and an external qualifier gates it. Both inputs are assumed to be already synchronous to the core clock `clk`. On each rising edge of the sample clock, if the qualifier is active and the slice is enabled, the slice puts the next byte of its working word on the bus. It begins with the least significant byte. For interleaved offset-binary samples, a word therefore leaves as I0, Q0, I1, Q1.

The working word is double-buffered behind a shadow register that the host writes through a plain write strobe. On the launch of the fourth byte of a word, the working register takes the shadow contents and a status flag rises. The flag tells the host that the shadow can be refilled. The host lowers the flag with a clear strobe. Between reloads, the working word rotates onto itself by one byte per launch. If the host misses a refill, the old shadow word is sent again unchanged. Both registers, and the output bus, come out of reset at mid-scale (0x80 per byte).

Top module: `byte_tx_slice`

## Requirements
- R1: Reset sets `dout` to 0x80, clears `swap_flag`, and loads both the working and shadow words with 0x80808080.
- R2: A rising edge of `smp_clk` seen while `qual` is high and `en` is high is a launch. On a launch, `dout` takes the least significant byte of the working word, one `clk` cycle later. Successive launches emit bytes [7:0], [15:8], [23:16], [31:24] in that order.
- R3: A rising edge of `smp_clk` while `qual` is low launches nothing, leaves `dout` unchanged and does not advance the byte position.
- R4: Holding `smp_clk` high for several cycles causes exactly one launch; a launch needs a low-to-high transition.
- R5: The fourth launch of a word loads the working word from the shadow word, so the following launch emits the shadow's byte [7:0]. A shadow write in the same cycle as that fourth launch is not used for this reload; it is used at the next one.
- R6: `swap_flag` goes high in the cycle after the fourth launch and stays high until a `flag_clr` strobe. If a clear and a reload fall in the same cycle, the flag stays high.
- R7: If the shadow is not written between two reloads, the same shadow word is sent again unchanged.
- R8: While `en` is low, no launch happens, `dout` holds, and the byte position returns to 0. After `en` returns high, four further launches are needed before the next reload. The bytes continue from the working word as it was left.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Slice enable; low holds the slice idle and zeroes the byte position |
| smp_clk | input | 1 | External sample clock, synchronous to `clk`; its rising edge paces launches |
| qual | input | 1 | External qualifier; a launch needs it high |
| sh_wr | input | 1 | Write strobe for the shadow word |
| sh_data | input | 32 | Word written to the shadow on `sh_wr` |
| flag_clr | input | 1 | Strobe that clears `swap_flag` |
| dout | output | 8 | Registered parallel sample output |
| swap_flag | output | 1 | Registered status: high after a shadow-to-working reload, until cleared |

## Verification
The bench aims at the launch count around a reload. If the position counter were off by one, the shadow bytes would appear one launch early or late, and the flag would rise at the wrong moment. It holds the sample clock high for several cycles to expose a level-sensitive design, which would emit a burst of bytes. It drives a clear and a reload in the same cycle to catch a design that gives the clear priority and loses the notification. It writes the shadow in the same cycle as the reload to catch a design that forwards the new word one swap too early. It also toggles the enable mid-word, where a design that kept its position would reload after two bytes instead of four.

// File: rtl/bts_pkg.sv
package bts_pkg;

  // Active level of the external qualifier input.
  typedef enum logic {
    QUAL_ACT_HIGH = 1'b0,
    QUAL_ACT_LOW  = 1'b1
  } qual_pol_e;

endpackage

// File: rtl/bts_edge_qual.sv
// Detects a rising edge of the sample clock and gates it with the
// qualifier and the enable. Output is a single-cycle launch pulse.
module bts_edge_qual #(
  parameter bts_pkg::qual_pol_e QUAL_POL = bts_pkg::QUAL_ACT_HIGH
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic smp_clk,
  input  logic qual,
  output logic launch
);

  logic smp_prev;
  logic qual_on;

  always_ff @(posedge clk) begin
    if (rst) smp_prev <= 1'b0;
    else     smp_prev <= smp_clk;
  end

  generate
    if (QUAL_POL == bts_pkg::QUAL_ACT_HIGH) begin : g_qual_hi
      assign qual_on = qual;
    end else begin : g_qual_lo
      assign qual_on = ~qual;
    end
  endgenerate

  assign launch = en & qual_on & smp_clk & ~smp_prev;

endmodule

// File: rtl/bts_shadow.sv
// Host-side shadow word and the reload status flag.
module bts_shadow #(
  parameter int unsigned          WORD_W    = 32,
  parameter logic [WORD_W-1:0]    IDLE_WORD = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              reload,
  input  logic              clr,
  output logic [WORD_W-1:0] shadow,
  output logic              flag
);

  always_ff @(posedge clk) begin
    if (rst)     shadow <= IDLE_WORD;
    else if (wr) shadow <= wdata;
  end

  // A reload outranks a clear arriving in the same cycle.
  always_ff @(posedge clk) begin
    if (rst)         flag <= 1'b0;
    else if (reload) flag <= 1'b1;
    else if (clr)    flag <= 1'b0;
  end

endmodule

// File: rtl/bts_lane_rotor.sv
// Working word, byte position and registered output lane.
module bts_lane_rotor #(
  parameter int unsigned       LANE_W    = 8,
  parameter int unsigned       LANES     = 4,
  parameter int unsigned       WORD_W    = LANE_W * LANES,
  parameter logic [WORD_W-1:0] IDLE_WORD = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              launch,
  input  logic [WORD_W-1:0] reload_word,
  output logic [LANE_W-1:0] lane_out,
  output logic              reload
);

  localparam int unsigned POS_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(LANES - 1);

  logic [WORD_W-1:0] work;
  logic [WORD_W-1:0] rotated;
  logic [POS_W-1:0]  pos;
  logic              at_last;

  // Self-loop: the lane sent out re-enters at the top of the word.
  generate
    for (genvar g = 0; g < LANES; g++) begin : g_rot
      localparam int unsigned SRC = (g + 1) % LANES;
      assign rotated[g*LANE_W +: LANE_W] = work[SRC*LANE_W +: LANE_W];
    end
  endgenerate

  assign at_last = (pos == LAST_POS);
  assign reload  = launch & at_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      work     <= IDLE_WORD;
      pos      <= '0;
      lane_out <= IDLE_WORD[LANE_W-1:0];
    end else if (!en) begin
      pos <= '0;
    end else if (launch) begin
      lane_out <= work[LANE_W-1:0];
      if (at_last) begin
        work <= reload_word;
        pos  <= '0;
      end else begin
        work <= rotated;
        pos  <= pos + POS_W'(1);
      end
    end
  end

endmodule

// File: rtl/byte_tx_slice.sv
module byte_tx_slice #(
  parameter int unsigned          LANE_W    = 8,
  parameter int unsigned          LANES     = 4,
  parameter logic [LANE_W-1:0]    IDLE_LANE = 8'h80,
  parameter bts_pkg::qual_pol_e   QUAL_POL  = bts_pkg::QUAL_ACT_HIGH
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic                      smp_clk,
  input  logic                      qual,
  input  logic                      sh_wr,
  input  logic [LANE_W*LANES-1:0]   sh_data,
  input  logic                      flag_clr,
  output logic [LANE_W-1:0]         dout,
  output logic                      swap_flag
);

  localparam int unsigned       WORD_W    = LANE_W * LANES;
  localparam logic [WORD_W-1:0] IDLE_WORD = {LANES{IDLE_LANE}};

  logic              launch;
  logic              reload;
  logic [WORD_W-1:0] shadow;

  bts_edge_qual #(
    .QUAL_POL(QUAL_POL)
  ) edge_i (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .smp_clk(smp_clk),
    .qual   (qual),
    .launch (launch)
  );

  bts_lane_rotor #(
    .LANE_W   (LANE_W),
    .LANES    (LANES),
    .WORD_W   (WORD_W),
    .IDLE_WORD(IDLE_WORD)
  ) rotor_i (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .launch     (launch),
    .reload_word(shadow),
    .lane_out   (dout),
    .reload     (reload)
  );

  bts_shadow #(
    .WORD_W   (WORD_W),
    .IDLE_WORD(IDLE_WORD)
  ) shadow_i (
    .clk   (clk),
    .rst   (rst),
    .wr    (sh_wr),
    .wdata (sh_data),
    .reload(reload),
    .clr   (flag_clr),
    .shadow(shadow),
    .flag  (swap_flag)
  );

endmodule

// File: rtl/byte_tx_slice_chk.sv
module byte_tx_slice_chk #(
  parameter int unsigned        LANE_W    = 8,
  parameter logic [LANE_W-1:0]  IDLE_LANE = 8'h80,
  parameter bts_pkg::qual_pol_e QUAL_POL  = bts_pkg::QUAL_ACT_HIGH
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              qual,
  input logic              launch,
  input logic              reload,
  input logic              flag_clr,
  input logic [LANE_W-1:0] dout,
  input logic              swap_flag
);

  logic qual_off;
  assign qual_off = (QUAL_POL == bts_pkg::QUAL_ACT_HIGH) ? !qual : qual;

  // R1: the cycle after reset shows the idle state
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dout == IDLE_LANE) && !swap_flag);

  // R2: the output bus moves only on a launch
  assert_hold_no_launch_R2: assert property (@(posedge clk) disable iff (rst)
    !launch |=> $stable(dout));

  // R3: an inactive qualifier blocks any change of the bus
  assert_qual_gate_R3: assert property (@(posedge clk) disable iff (rst)
    qual_off |=> $stable(dout));

  // R8: a disabled slice neither changes the bus nor raises the flag
  assert_disabled_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(dout) && !$rose(swap_flag));

  // R6: the flag rises only after a reload
  assert_flag_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(swap_flag) |-> $past(reload));

  // R6: a clear without a competing reload lowers the flag
  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !reload) |=> !swap_flag);

  // R5: a reload happens only on a launch
  assert_reload_on_launch_R5: assert property (@(posedge clk) disable iff (rst)
    reload |-> launch);

endmodule

bind byte_tx_slice byte_tx_slice_chk #(
  .LANE_W   (LANE_W),
  .IDLE_LANE(IDLE_LANE),
  .QUAL_POL (QUAL_POL)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .qual     (qual),
  .launch   (launch),
  .reload   (reload),
  .flag_clr (flag_clr),
  .dout     (dout),
  .swap_flag(swap_flag)
);

// File: tb/byte_tx_slice_tb_top.sv
`timescale 1ns/1ps
module byte_tx_slice_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b1;
  logic        smp_clk = 1'b0;
  logic        qual = 1'b0;
  logic        sh_wr = 1'b0;
  logic [31:0] sh_data = '0;
  logic        flag_clr = 1'b0;
  logic [7:0]  dout;
  logic        swap_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  byte_tx_slice dut_i (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .smp_clk  (smp_clk),
    .qual     (qual),
    .sh_wr    (sh_wr),
    .sh_data  (sh_data),
    .flag_clr (flag_clr),
    .dout     (dout),
    .swap_flag(swap_flag)
  );

  // Vector layout: [43] write shadow first, [42] clear flag first,
  // [41] qualifier during the edge, [40:9] shadow word,
  // [8:1] expected dout, [0] expected flag.
  localparam int NVEC = 17;
  localparam logic [43:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 1'b1, 32'h44332211, 8'h80, 1'b0},  // R1 working still idle
    {1'b0, 1'b0, 1'b1, 32'h0,        8'h80, 1'b0},
    {1'b0, 1'b0, 1'b1, 32'h0,        8'h80, 1'b0},
    {1'b0, 1'b0, 1'b1, 32'h0,        8'h80, 1'b1},  // R6 fourth launch
    {1'b0, 1'b1, 1'b1, 32'h0,        8'h11, 1'b0},  // R5 shadow byte 0
    {1'b0, 1'b0, 1'b0, 32'h0,        8'h11, 1'b0},  // R3 qualifier low
    {1'b0, 1'b0, 1'b1, 32'h0,        8'h22, 1'b0},  // R2
    {1'b0, 1'b0, 1'b1, 32'h0,        8'h33, 1'b0},
    {1'b1, 1'b0, 1'b1, 32'hDDCCBBAA, 8'h44, 1'b1},
    {1'b0, 1'b0, 1'b1, 32'h0,        8'hAA, 1'b1},  // R6 flag holds
    {1'b0, 1'b0, 1'b1, 32'h0,        8'hBB, 1'b1},
    {1'b0, 1'b1, 1'b1, 32'h0,        8'hCC, 1'b0},
    {1'b0, 1'b0, 1'b1, 32'h0,        8'hDD, 1'b1},
    {1'b0, 1'b1, 1'b1, 32'h0,        8'hAA, 1'b0},  // R7 word repeats
    {1'b0, 1'b0, 1'b1, 32'h0,        8'hBB, 1'b0},
    {1'b0, 1'b0, 1'b1, 32'h0,        8'hCC, 1'b0},
    {1'b0, 1'b0, 1'b1, 32'h0,        8'hDD, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic strobe_wr(input logic [31:0] d);
    @(negedge clk);
    sh_wr = 1'b1; sh_data = d;
    @(negedge clk);
    sh_wr = 1'b0;
  endtask

  task automatic strobe_clr();
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  // One sample-clock period; results are stable at return.
  task automatic edge_pulse(input logic q, input logic c, input logic w, input logic [31:0] d);
    @(negedge clk);
    smp_clk = 1'b1; qual = q; flag_clr = c; sh_wr = w; sh_data = d;
    @(negedge clk);
    smp_clk = 1'b0; flag_clr = 1'b0; sh_wr = 1'b0;
  endtask

  task automatic expect_byte(input string tag, input logic [7:0] b, input logic f);
    edge_pulse(1'b1, 1'b0, 1'b0, 32'h0);
    check({tag, " dout"}, {24'h0, dout}, {24'h0, b});
    check({tag, " flag"}, {31'h0, swap_flag}, {31'h0, f});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset dout", {24'h0, dout}, 32'h80);
    check("R1 reset flag", {31'h0, swap_flag}, 32'h0);

    // Table walk.
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][43]) strobe_wr(VEC[i][40:9]);
      if (VEC[i][42]) strobe_clr();
      edge_pulse(VEC[i][41], 1'b0, 1'b0, 32'h0);
      check($sformatf("R2/R5/R6/R7 vec%0d dout", i), {24'h0, dout}, {24'h0, VEC[i][8:1]});
      check($sformatf("R6 vec%0d flag", i), {31'h0, swap_flag}, {31'h0, VEC[i][0]});
    end

    // R4: sample clock held high gives one launch only.
    strobe_clr();
    @(negedge clk);
    smp_clk = 1'b1; qual = 1'b1;
    repeat (4) @(negedge clk);
    check("R4 held high dout", {24'h0, dout}, 32'hAA);
    smp_clk = 1'b0;
    expect_byte("R4 next edge", 8'hBB, 1'b0);

    // R8: disabled edges are ignored and the position restarts at 0.
    @(negedge clk);
    en = 1'b0;
    edge_pulse(1'b1, 1'b0, 1'b0, 32'h0);
    check("R8 disabled dout", {24'h0, dout}, 32'hBB);
    check("R8 disabled flag", {31'h0, swap_flag}, 32'h0);
    @(negedge clk);
    en = 1'b1;
    expect_byte("R8 resume 1", 8'hCC, 1'b0);
    expect_byte("R8 resume 2", 8'hDD, 1'b0);
    expect_byte("R8 resume 3", 8'hAA, 1'b0);
    expect_byte("R8 resume 4", 8'hBB, 1'b1);

    // R6 set wins over clear; R5 same-cycle write is deferred.
    strobe_clr();
    expect_byte("R5 word a0", 8'hAA, 1'b0);
    expect_byte("R5 word a1", 8'hBB, 1'b0);
    expect_byte("R5 word a2", 8'hCC, 1'b0);
    edge_pulse(1'b1, 1'b1, 1'b1, 32'h0F0E0D0C);
    check("R6 set beats clear dout", {24'h0, dout}, 32'hDD);
    check("R6 set beats clear flag", {31'h0, swap_flag}, 32'h1);
    expect_byte("R5 old shadow b0", 8'hAA, 1'b1);
    expect_byte("R5 old shadow b1", 8'hBB, 1'b1);
    expect_byte("R5 old shadow b2", 8'hCC, 1'b1);
    expect_byte("R5 old shadow b3", 8'hDD, 1'b1);
    expect_byte("R5 new shadow b0", 8'h0C, 1'b1);
    expect_byte("R5 new shadow b1", 8'h0D, 1'b1);

    // R1: reset mid-stream restores idle working and shadow words.
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 re-reset dout", {24'h0, dout}, 32'h80);
    check("R1 re-reset flag", {31'h0, swap_flag}, 32'h0);
    expect_byte("R1 idle w0", 8'h80, 1'b0);
    expect_byte("R1 idle w1", 8'h80, 1'b0);
    expect_byte("R1 idle w2", 8'h80, 1'b0);
    expect_byte("R1 idle w3", 8'h80, 1'b1);
    expect_byte("R1 idle shadow", 8'h80, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule